// File: doc/BRIEF.md
# Linked-Descriptor Stream DMA Engine

This engine moves data between a word-addressed memory and a streaming port. The data is described by a chain of three-word descriptors that software builds in memory. A configuration write loads the chain head and arms a start request. The engine then walks the chain one descriptor at a time. For each descriptor it reads the control word and checks that the hardware owns it. It then reads the buffer address and the link to the following descriptor, moves the buffer contents and follows the link. A zero link ends the walk, and so does a descriptor that software still owns. The direction is chosen when the walk starts.

In the transmit direction, buffer words are read from memory and offered on a valid/ready output stream. The output carries a byte count for each beat, a frame-end marker and a sub-frame-start marker. The output holds its beat until the sink accepts it, so a slow sink simply stalls the walk. In the receive direction, words arrive on a valid/ready input stream and are written into the buffer. The engine raises `rx_ready` only while it can take a word, so the source must hold its beat until the handshake. When a buffer fills or a frame ends, the engine rewrites the descriptor's control word to hand the buffer back to software. The memory side uses a single-word request that is held until `mem_ready`. Read data is taken in the same cycle as `mem_ready`.

Descriptor layout, word by word at increasing addresses:
- Control word: bit 31 hardware-owns, bit 30 frame-end, bit 29 sub-frame-start, bits 28:24 zero, bits 23:12 valid byte count, bits 11:0 buffer capacity in bytes.
- Buffer start address.
- Link to the following descriptor (zero = none).

Top module: `ldma_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `start_pending`, `done`, `err`, `mem_req` and `tx_valid` are all 0.
- R2: While the engine is idle, a `cfg_wr` with `cfg_wdata[29]`=1 arms a start. The first descriptor read goes to address {HEAD_BASE, `cfg_wdata[19:0]`}. `start_pending` falls when the walk begins. Configuration writes made while `busy` is 1 are ignored.
- R3: Descriptor fields are decoded at the positions given in the layout above. The transmit direction never writes a descriptor back.
- R4: If a control word has bit 31 = 0, the walk ends right after that one read. The buffer is not touched and no further memory request is made.
- R5: Transmit sends ceil(count/4) beats. The beats come from consecutive buffer words. `tx_nbytes` is 4 on each beat except the final beat of a descriptor, where it is the remaining 1 to 4 bytes. `tx_last` marks the final beat of a frame-end descriptor. `tx_sof` marks the first beat of a descriptor that has the sub-frame-start flag.
- R6: On transmit, the engine checks each frame-end descriptor before moving any data. The bytes sent earlier in the frame plus that descriptor's count must equal `tx_frame_len`. If they do not, `err` pulses together with `done`, the walk ends and that descriptor sends no beats.
- R7: Receive writes the accepted words to consecutive buffer words. It stops when the capacity is reached or when a beat with `rx_last` has been written. It then writes the control word back: bit 31 = 0, bit 30 = 1 only if `rx_last` ended the buffer, bit 29 and the capacity kept, and the count set to 4 × words written, capped at the capacity.
- R8: After a descriptor completes, a nonzero link is fetched next. A zero link ends the walk.
- R9: `mem_req` holds its address, write enable and write data until `mem_ready`. `tx_valid` holds its beat until `tx_ready`. `tx_valid` and `rx_ready` are never high together.
- R10: Every walk ends with a `done` pulse that lasts exactly one cycle.
- R11: A transmit descriptor with a count of 0 sends no beat, and the walk proceeds to its link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the head/start register |
| cfg_wdata | input | 32 | Bits 19:0 chain head, bit 29 start |
| xfer_dir | input | 1 | 0 transmit, 1 receive; sampled at start |
| tx_frame_len | input | 16 | Expected transmit frame length in bytes |
| busy | output | 1 | Walk in progress |
| start_pending | output | 1 | Start armed but not yet taken |
| done | output | 1 | One-cycle end-of-walk pulse |
| err | output | 1 | Frame length mismatch, pulses with done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Request accepted |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit sink accepts |
| tx_data | output | 32 | Transmit word |
| tx_nbytes | output | 3 | Valid bytes in the beat (1-4) |
| tx_last | output | 1 | Final beat of a frame |
| tx_sof | output | 1 | First beat of a sub-frame |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Engine accepts a receive beat |
| rx_data | input | 32 | Receive word |
| rx_last | input | 1 | Receive beat ends the frame |

## Verification
The bench walks a chain whose frame spans two descriptors, and the last word of the first descriptor is partial. A design with an off-by-one in the beat count would send an extra beat or report a wrong byte count. Separate walks cover a software-owned head, a frame-end descriptor whose count disagrees with the frame length, and a zero-count descriptor. A wrong design would touch the buffer, send beats it should withhold, or stall. In the receive walk the frame ends inside a second, larger buffer. Its write-back must report only the bytes written and set the frame-end flag, while the first write-back keeps the sub-frame-start flag. Memory and both streams stall on irregular patterns throughout, and a start written during a walk must leave no armed request behind.

// File: rtl/ldma_pkg.sv
package ldma_pkg;
  localparam int WORD_W    = 32;
  localparam int CNT_W     = 12;
  localparam int WORD_B    = WORD_W / 8;

  typedef struct packed {
    logic             hw_own;
    logic             frm_end;
    logic             sub_start;
    logic [4:0]       pad;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cap;
  } ctl_word_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CTL, ST_BUF, ST_LNK, ST_RD, ST_PUSH,
    ST_ACC, ST_WR, ST_WB, ST_ADV, ST_END
  } walk_st_t;
endpackage

// File: rtl/ldma_head_reg.sv
module ldma_head_reg #(
  parameter int ADDR_W = 32,
  parameter int HEAD_W = 20,
  parameter logic [ADDR_W-HEAD_W-1:0] HEAD_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [HEAD_W-1:0] wr_head,
  input  logic              wr_start,
  input  logic              idle,
  output logic              launch,
  output logic [ADDR_W-1:0] head_addr,
  output logic              pending
);
  logic [HEAD_W-1:0] head_q;

  assign launch    = pending && idle;
  assign head_addr = {HEAD_BASE, head_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      pending <= 1'b0;
    end else if (launch) begin
      pending <= 1'b0;
    end else if (wr_en && idle) begin
      head_q  <= wr_head;
      pending <= wr_start;
    end
  end
endmodule

// File: rtl/ldma_beat_ctr.sv
module ldma_beat_ctr #(
  parameter int CNT_W  = 12,
  parameter int WORD_B = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] total,
  input  logic             step,
  output logic [CNT_W-1:0] offset,
  output logic [2:0]       nbytes,
  output logic             last
);
  logic [CNT_W-1:0] rem_q;

  assign last   = rem_q <= CNT_W'(WORD_B);
  assign nbytes = last ? rem_q[2:0] : 3'(WORD_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      offset <= '0;
    end else if (load) begin
      rem_q  <= total;
      offset <= '0;
    end else if (step) begin
      rem_q  <= rem_q - CNT_W'(nbytes);
      offset <= offset + CNT_W'(nbytes);
    end
  end
endmodule

// File: rtl/ldma_frame_chk.sv
module ldma_frame_chk #(
  parameter int FLEN_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add,
  input  logic              add_eof,
  input  logic [CNT_W-1:0]  add_len,
  input  logic [CNT_W-1:0]  probe_len,
  input  logic [FLEN_W-1:0] frame_len,
  output logic              mismatch
);
  logic [FLEN_W-1:0] sent_q;

  assign mismatch = (sent_q + FLEN_W'(probe_len)) != frame_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sent_q <= '0;
    else if (clr)     sent_q <= '0;
    else if (add)     sent_q <= add_eof ? '0 : sent_q + FLEN_W'(add_len);
  end
endmodule

// File: rtl/ldma_engine.sv
module ldma_engine
  import ldma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int HEAD_W    = 20,
  parameter int START_BIT = 29,
  parameter int FLEN_W    = 16,
  parameter logic [ADDR_W-HEAD_W-1:0] HEAD_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  input  logic              xfer_dir,
  input  logic [FLEN_W-1:0] tx_frame_len,
  output logic              busy,
  output logic              start_pending,
  output logic              done,
  output logic              err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ready,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  output logic [2:0]        tx_nbytes,
  output logic              tx_last,
  output logic              tx_sof,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [31:0]       rx_data,
  input  logic              rx_last
);
  localparam logic [ADDR_W-1:0] OFS_BUF = ADDR_W'(WORD_B);
  localparam logic [ADDR_W-1:0] OFS_LNK = ADDR_W'(2 * WORD_B);

  walk_st_t          st;
  ctl_word_t         ctl_q, ctl_in, ctl_wb;
  logic [ADDR_W-1:0] cur_q, buf_q, lnk_q, head_addr;
  logic [31:0]       data_q;
  logic              dir_q, fin_q, err_q;
  logic              launch, mismatch, hs;
  logic              beat_load, beat_step, beat_last;
  logic [CNT_W-1:0]  beat_off, beat_total;
  logic [2:0]        beat_nb;

  ldma_head_reg #(.ADDR_W(ADDR_W), .HEAD_W(HEAD_W), .HEAD_BASE(HEAD_BASE)) u_head (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_head(cfg_wdata[HEAD_W-1:0]),
    .wr_start(cfg_wdata[START_BIT]), .idle(st == ST_IDLE), .launch(launch),
    .head_addr(head_addr), .pending(start_pending)
  );

  ldma_beat_ctr #(.CNT_W(CNT_W), .WORD_B(WORD_B)) u_beat (
    .clk(clk), .rst_n(rst_n), .load(beat_load), .total(beat_total),
    .step(beat_step), .offset(beat_off), .nbytes(beat_nb), .last(beat_last)
  );

  ldma_frame_chk #(.FLEN_W(FLEN_W), .CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .clr(launch), .add(st == ST_ADV && !dir_q),
    .add_eof(ctl_q.frm_end), .add_len(ctl_q.count), .probe_len(ctl_in.count),
    .frame_len(tx_frame_len), .mismatch(mismatch)
  );

  assign ctl_in = ctl_word_t'(mem_rdata);

  always_comb begin
    ctl_wb           = ctl_q;
    ctl_wb.hw_own    = 1'b0;
    ctl_wb.frm_end   = fin_q;
    ctl_wb.pad       = '0;
    ctl_wb.count     = beat_off;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      ST_CTL: begin mem_req = 1'b1; mem_addr = cur_q; end
      ST_BUF: begin mem_req = 1'b1; mem_addr = cur_q + OFS_BUF; end
      ST_LNK: begin mem_req = 1'b1; mem_addr = cur_q + OFS_LNK; end
      ST_RD:  begin mem_req = 1'b1; mem_addr = buf_q + ADDR_W'(beat_off); end
      ST_WR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = buf_q + ADDR_W'(beat_off); mem_wdata = data_q;
      end
      ST_WB: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = cur_q; mem_wdata = 32'(ctl_wb);
      end
      default: ;
    endcase
  end

  assign hs         = mem_req && mem_ready;
  assign beat_load  = (st == ST_LNK) && hs;
  assign beat_total = dir_q ? ctl_q.cap : ctl_q.count;
  assign beat_step  = (st == ST_PUSH && tx_ready) || (st == ST_WR && mem_ready);

  assign busy      = st != ST_IDLE;
  assign done      = st == ST_END;
  assign err       = err_q;
  assign tx_valid  = st == ST_PUSH;
  assign tx_data   = data_q;
  assign tx_nbytes = beat_nb;
  assign tx_last   = ctl_q.frm_end && beat_last;
  assign tx_sof    = ctl_q.sub_start && (beat_off == '0);
  assign rx_ready  = st == ST_ACC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ctl_q  <= '0;
      cur_q  <= '0;
      buf_q  <= '0;
      lnk_q  <= '0;
      data_q <= '0;
      dir_q  <= 1'b0;
      fin_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (launch) begin
          cur_q <= head_addr;
          dir_q <= xfer_dir;
          st    <= ST_CTL;
        end
        ST_CTL: if (mem_ready) begin
          ctl_q <= ctl_in;
          if (!ctl_in.hw_own) st <= ST_END;
          else if (!dir_q && ctl_in.frm_end && mismatch) begin
            err_q <= 1'b1;
            st    <= ST_END;
          end else st <= ST_BUF;
        end
        ST_BUF: if (mem_ready) begin
          buf_q <= mem_rdata;
          st    <= ST_LNK;
        end
        ST_LNK: if (mem_ready) begin
          lnk_q <= mem_rdata;
          fin_q <= 1'b0;
          if (dir_q) st <= (ctl_q.cap == '0) ? ST_WB : ST_ACC;
          else       st <= (ctl_q.count == '0) ? ST_ADV : ST_RD;
        end
        ST_RD: if (mem_ready) begin
          data_q <= mem_rdata;
          st     <= ST_PUSH;
        end
        ST_PUSH: if (tx_ready) st <= beat_last ? ST_ADV : ST_RD;
        ST_ACC: if (rx_valid) begin
          data_q <= rx_data;
          fin_q  <= rx_last;
          st     <= ST_WR;
        end
        ST_WR: if (mem_ready) st <= (beat_last || fin_q) ? ST_WB : ST_ACC;
        ST_WB: if (mem_ready) st <= ST_ADV;
        ST_ADV: begin
          if (lnk_q == '0) st <= ST_END;
          else begin
            cur_q <= lnk_q;
            st    <= ST_CTL;
          end
        end
        ST_END: begin
          err_q <= 1'b0;
          st    <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldma_engine_chk.sv
module ldma_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              start_pending,
  input logic              done,
  input logic              err,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [31:0]       tx_data,
  input logic              rx_ready
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !tx_valid && !rx_ready));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !start_pending);

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R9
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind ldma_engine ldma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start_pending(start_pending),
  .done(done), .err(err), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .rx_ready(rx_ready)
);

// File: tb/sim_ldma_engine.sv
module sim_ldma_engine;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cfg_wr, xfer_dir;
  logic [31:0] cfg_wdata;
  logic [15:0] tx_frame_len;
  logic        busy, start_pending, done, err;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, tx_last, tx_sof;
  logic [31:0] tx_data;
  logic [2:0]  tx_nbytes;
  logic        rx_valid, rx_ready, rx_last;
  logic [31:0] rx_data;

  logic [31:0] mem [256];
  assign mem_rdata = mem[mem_addr[9:2]];

  ldma_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .xfer_dir(xfer_dir), .tx_frame_len(tx_frame_len), .busy(busy),
    .start_pending(start_pending), .done(done), .err(err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_nbytes(tx_nbytes), .tx_last(tx_last), .tx_sof(tx_sof),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last)
  );

  typedef struct { logic [31:0] d; logic [2:0] nb; logic last; logic sof; } tx_exp_t;
  typedef struct { logic [31:0] a; logic [31:0] d; } wr_exp_t;
  typedef struct { logic [31:0] d; logic last; } rx_item_t;
  tx_exp_t  txq[$];
  wr_exp_t  wrq[$];
  rx_item_t rxq[$];
  tx_exp_t  tx_e;
  wr_exp_t  wr_e;

  int n_pass = 0, n_total = 0;
  int cyc = 0, done_cnt = 0, err_cnt = 0, mem_hs = 0, tx_beats = 0;
  logic [31:0] first_addr;
  bit want_first = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  // stimulus for ready/valid inputs plus the scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    mem_ready = (cyc % 3) != 1;
    tx_ready  = (cyc % 4) != 2;
    if (rxq.size() > 0) begin
      rx_valid = 1'b1; rx_data = rxq[0].d; rx_last = rxq[0].last;
    end else begin
      rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0;
    end
    if (rst_n) begin
      if (done) done_cnt++;
      if (err)  err_cnt++;
      if (rx_valid && rx_ready) void'(rxq.pop_front());
      if (mem_req && want_first) begin first_addr = mem_addr; want_first = 0; end
      if (mem_req && mem_ready) begin
        mem_hs++;
        if (mem_we) begin
          if (wrq.size() == 0) check(1'b0, "R3/R7 unexpected write", mem_addr, '0);
          else begin
            wr_e = wrq.pop_front();
            check(mem_addr == wr_e.a, "R7 write address", mem_addr, wr_e.a);
            check(mem_wdata == wr_e.d, "R7 write data", mem_wdata, wr_e.d);
          end
          mem[mem_addr[9:2]] = mem_wdata;
        end
      end
      if (tx_valid && tx_ready) begin
        tx_beats++;
        if (txq.size() == 0) check(1'b0, "R5 unexpected beat", tx_data, '0);
        else begin
          tx_e = txq.pop_front();
          check(tx_data == tx_e.d, "R5 beat data", tx_data, tx_e.d);
          check({tx_nbytes, tx_last, tx_sof} == {tx_e.nb, tx_e.last, tx_e.sof},
                "R5 beat nbytes/last/sof", 32'({tx_nbytes, tx_last, tx_sof}),
                32'({tx_e.nb, tx_e.last, tx_e.sof}));
        end
      end
    end
  end

  task automatic put_desc(input logic [31:0] a, input logic [31:0] c,
                          input logic [31:0] b, input logic [31:0] n);
    mem[a[9:2]] = c; mem[a[9:2] + 1] = b; mem[a[9:2] + 2] = n;
  endtask

  task automatic start_walk(input logic [19:0] head, input bit dir);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 32'h2000_0000 | 32'(head); xfer_dir = dir;
    want_first = 1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic wait_done(input int d0);
    int guard = 0;
    while (done_cnt == d0 && guard < 3000) begin @(negedge clk); guard++; end
    check(done_cnt == d0 + 1, "R10 walk ended with done", 32'(done_cnt), 32'(d0 + 1));
    repeat (3) @(negedge clk);
    check(done_cnt == d0 + 1, "R10 single done pulse", 32'(done_cnt), 32'(d0 + 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    int d0, e0, h0, b0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; xfer_dir = 1'b0;
    tx_frame_len = '0; tx_ready = 1'b0; mem_ready = 1'b0;
    rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check({busy, start_pending, done, err, mem_req, tx_valid} == '0, "R1 reset idle",
          32'({busy, start_pending, done, err, mem_req, tx_valid}), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !mem_req, "R1 idle after release", 32'({busy, mem_req}), '0);

    // two-descriptor transmit frame, partial word, sub-frame start
    tx_frame_len = 16'd10;
    put_desc(32'h040, 32'hA000_6008, 32'h200, 32'h060);
    put_desc(32'h060, 32'hC000_4004, 32'h240, 32'h000);
    mem[32'h200 >> 2] = 32'h1122_3344; mem[32'h204 >> 2] = 32'h5566_7788;
    mem[32'h240 >> 2] = 32'h99AA_BBCC;
    txq.push_back('{32'h1122_3344, 3'd4, 1'b0, 1'b1});
    txq.push_back('{32'h5566_7788, 3'd2, 1'b0, 1'b0});
    txq.push_back('{32'h99AA_BBCC, 3'd4, 1'b1, 1'b0});
    d0 = done_cnt; e0 = err_cnt;
    start_walk(20'h00040, 1'b0);
    wait_done(d0);
    check(first_addr == 32'h040, "R2 first fetch at head", first_addr, 32'h040);
    check(!start_pending, "R2 start request consumed", 32'(start_pending), '0);
    check(txq.size() == 0, "R5 R8 all beats sent", 32'(txq.size()), '0);
    check(err_cnt == e0, "R6 matching frame no err", 32'(err_cnt - e0), '0);
    check(mem[32'h040 >> 2] == 32'hA000_6008, "R3 tx no write-back",
          mem[32'h040 >> 2], 32'hA000_6008);

    // software-owned head
    put_desc(32'h080, 32'h4000_4004, 32'h200, 32'h040);
    d0 = done_cnt; h0 = mem_hs; b0 = tx_beats;
    start_walk(20'h00080, 1'b0);
    wait_done(d0);
    check(mem_hs - h0 == 1, "R4 only control word read", 32'(mem_hs - h0), 32'd1);
    check(tx_beats == b0, "R4 no beats", 32'(tx_beats - b0), '0);

    // frame-end count disagrees with the frame length
    put_desc(32'h100, 32'hC000_5008, 32'h200, 32'h000);
    d0 = done_cnt; e0 = err_cnt; b0 = tx_beats;
    start_walk(20'h00100, 1'b0);
    wait_done(d0);
    check(err_cnt - e0 == 1, "R6 mismatch flagged", 32'(err_cnt - e0), 32'd1);
    check(tx_beats == b0, "R6 no beats on mismatch", 32'(tx_beats - b0), '0);

    // receive: frame ends inside the second buffer
    put_desc(32'h0A0, 32'hA000_0008, 32'h280, 32'h0C0);
    put_desc(32'h0C0, 32'h8000_0010, 32'h2C0, 32'h000);
    rxq.push_back('{32'hCAFE_0001, 1'b0});
    rxq.push_back('{32'hCAFE_0002, 1'b0});
    rxq.push_back('{32'hCAFE_0003, 1'b1});
    wrq.push_back('{32'h280, 32'hCAFE_0001});
    wrq.push_back('{32'h284, 32'hCAFE_0002});
    wrq.push_back('{32'h0A0, 32'h2000_8008});
    wrq.push_back('{32'h2C0, 32'hCAFE_0003});
    wrq.push_back('{32'h0C0, 32'h4000_4010});
    d0 = done_cnt;
    start_walk(20'h000A0, 1'b1);
    wait_done(d0);
    check(wrq.size() == 0, "R7 all writes seen", 32'(wrq.size()), '0);
    check(rxq.size() == 0, "R7 all rx beats taken", 32'(rxq.size()), '0);
    check(mem[32'h0C0 >> 2] == 32'h4000_4010, "R7 R8 final write-back",
          mem[32'h0C0 >> 2], 32'h4000_4010);

    // zero-count descriptor skipped, then a 3-byte frame
    tx_frame_len = 16'd3;
    put_desc(32'h0E0, 32'h8000_0000, 32'h000, 32'h0F0);
    put_desc(32'h0F0, 32'hC000_3004, 32'h300, 32'h000);
    mem[32'h300 >> 2] = 32'hDEAD_BEEF;
    txq.push_back('{32'hDEAD_BEEF, 3'd3, 1'b1, 1'b0});
    d0 = done_cnt; e0 = err_cnt;
    start_walk(20'h000E0, 1'b0);
    wait_done(d0);
    check(txq.size() == 0, "R11 skip then send", 32'(txq.size()), '0);
    check(err_cnt == e0, "R11 no err", 32'(err_cnt - e0), '0);

    // start written while busy must be ignored
    txq.push_back('{32'hDEAD_BEEF, 3'd3, 1'b1, 1'b0});
    d0 = done_cnt;
    start_walk(20'h000F0, 1'b0);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 32'h2000_0080;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
    wait_done(d0);
    repeat (4) @(negedge clk);
    check(!busy && !start_pending, "R2 busy write ignored",
          32'({busy, start_pending}), '0);
    check(txq.size() == 0, "R5 beat sent", 32'(txq.size()), '0);

    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule